// File: doc/BRIEF.md
# Boot-Select and Remap Address Decoder

This block turns the address of one bus master into a one-hot slave select. A system with several masters gives each master its own copy. Most of the address space maps to fixed slaves. The lowest megabyte has three possible targets. Before any remap, a boot-mode pin picks the target: internal boot ROM or external memory. After software issues a remap command, the lowest megabyte maps to internal SRAM. Exception vectors can then be rewritten at run time.

The boot-mode pin is captured while reset is held, and the last clock edge of reset decides the value. After that the pin has no effect. The remap state is a sticky flag. A one-cycle strobe sets it, and only reset clears it. The decode result is registered when a new address phase starts. It is then held for the whole transfer, so a remap that arrives in the middle of a transfer cannot redirect that transfer.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is low, and on the first cycle after it, `slv_sel` is 0, `dec_err` is 0 and the remap flag is clear. Clearing the flag means an access to the low region goes to the target chosen by the boot pin.
- R2: The value of `boot_ext` on the last rising edge with `rst_n` low sets the target of the low region (address bits [31:20] equal zero) before any remap. A value of 0 selects internal ROM (`slv_sel` = 4'b0001). A value of 1 selects external memory (`slv_sel` = 4'b0100). Changes to `boot_ext` after reset have no effect.
- R3: A one-cycle `remap_req` sets the remap flag at the next rising edge. An address phase that starts on a later cycle and hits the low region selects internal SRAM (4'b0010). An address phase that starts in the same cycle as the strobe still uses the old mapping. Only reset clears the flag.
- R4: The fixed regions decode the same way in every boot and remap state. Bits [31:20] = 0x001 select ROM (4'b0001). Bits [31:20] = 0x002 select SRAM (4'b0010). Bits [31:28] = 0x1 select external memory (4'b0100). Bits [31:20] = 0xFFF select the peripheral slave (4'b1000).
- R5: An address outside every region sets `dec_err` to 1 and `slv_sel` to 0.
- R6: `slv_sel` and `dec_err` update on the rising edge where `addr_start` is 1. They hold their values while `addr_start` is 0, whatever `addr` or `remap_req` do.
- R7: `slv_sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_ext | input | 1 | Boot-mode pin: 0 = internal ROM, 1 = external memory |
| remap_req | input | 1 | One-cycle strobe that sets the remap flag |
| addr_start | input | 1 | Marks the first cycle of a new address phase |
| addr | input | 32 | Master address |
| slv_sel | output | 4 | One-hot select: bit0 ROM, bit1 SRAM, bit2 external, bit3 peripherals |
| dec_err | output | 1 | Address hit no region |

## Verification
Some properties are checked by assertions on every cycle:
- `slv_sel` is one-hot or zero.
- An error never comes with a select.
- The outputs stay frozen between address phases.
- The remap flag is set by the strobe and then stays set.
- The captured boot value does not move outside reset.
- A remapped low-region access goes to SRAM.

Other behaviour needs the bench's ordered scenarios to show it:
- Which pin value wins at the end of reset.
- That a strobe in the same cycle as an address phase leaves that phase on the old target.
- That a second reset restores the boot mapping.
- That the fixed regions stay put in every mode.

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
  parameter int              AW       = 32,
  parameter int              TW       = 12,
  parameter int              EW       = 4,
  parameter logic [TW-1:0]   ROM_TAG  = 12'h001,
  parameter logic [TW-1:0]   SRAM_TAG = 12'h002,
  parameter logic [TW-1:0]   PERI_TAG = 12'hFFF,
  parameter logic [EW-1:0]   EXT_TAG  = 4'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_ext,
  input  logic          remap_req,
  input  logic          addr_start,
  input  logic [AW-1:0] addr,
  output logic [3:0]    slv_sel,
  output logic          dec_err
);

  localparam int S_ROM  = 0;
  localparam int S_SRAM = 1;
  localparam int S_EXT  = 2;
  localparam int S_PERI = 3;

  logic          boot_q;
  logic          remap_q;
  logic [TW-1:0] tag;
  logic          hit_low, hit_rom, hit_sram, hit_ext, hit_peri;
  logic [3:0]    nxt_sel;

  assign tag      = addr[AW-1 -: TW];
  assign hit_low  = (tag == '0);
  assign hit_rom  = (tag == ROM_TAG);
  assign hit_sram = (tag == SRAM_TAG);
  assign hit_peri = (tag == PERI_TAG);
  assign hit_ext  = (addr[AW-1 -: EW] == EXT_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= boot_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         remap_q <= 1'b0;
    else if (remap_req) remap_q <= 1'b1;
  end

  always_comb begin
    nxt_sel = '0;
    if (hit_low) begin
      if (remap_q)     nxt_sel[S_SRAM] = 1'b1;
      else if (boot_q) nxt_sel[S_EXT]  = 1'b1;
      else             nxt_sel[S_ROM]  = 1'b1;
    end
    else if (hit_rom)  nxt_sel[S_ROM]  = 1'b1;
    else if (hit_sram) nxt_sel[S_SRAM] = 1'b1;
    else if (hit_ext)  nxt_sel[S_EXT]  = 1'b1;
    else if (hit_peri) nxt_sel[S_PERI] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slv_sel <= '0;
      dec_err <= 1'b0;
    end else if (addr_start) begin
      slv_sel <= nxt_sel;
      dec_err <= ~|nxt_sel;
    end
  end

endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk #(
  parameter int AW = 32,
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          remap_req,
  input logic          addr_start,
  input logic [AW-1:0] addr,
  input logic [3:0]    slv_sel,
  input logic          dec_err,
  input logic          remapped,
  input logic          boot_lat
);

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_sel));

  p_err_nosel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (slv_sel == 4'b0000));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_start |=> ($stable(slv_sel) && $stable(dec_err)));

  p_remap_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    remap_req |=> remapped);

  p_remap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    remapped |=> remapped);

  p_boot_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(boot_lat));

  p_low_to_sram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_start && remapped && (addr[AW-1 -: TW] == '0)) |=> (slv_sel == 4'b0010));

endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .remap_req  (remap_req),
  .addr_start (addr_start),
  .addr       (addr),
  .slv_sel    (slv_sel),
  .dec_err    (dec_err),
  .remapped   (remap_q),
  .boot_lat   (boot_q)
);

// File: tb/sim_boot_remap_decoder.sv
`timescale 1ns/1ps
module sim_boot_remap_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_ext = 1'b0;
  logic        remap_req = 1'b0;
  logic        addr_start = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  slv_sel;
  logic        dec_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  boot_remap_decoder u0 (
    .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .remap_req(remap_req),
    .addr_start(addr_start), .addr(addr), .slv_sel(slv_sel), .dec_err(dec_err)
  );

  localparam int NV = 13;
  localparam logic [36:0] VEC [NV] = '{
    {32'h0000_0000, 4'b0001, 1'b0},
    {32'h000F_FFFC, 4'b0001, 1'b0},
    {32'h0010_0000, 4'b0001, 1'b0},
    {32'h0020_0040, 4'b0010, 1'b0},
    {32'h002F_FFFF, 4'b0010, 1'b0},
    {32'h1000_0000, 4'b0100, 1'b0},
    {32'h1FFF_FFF0, 4'b0100, 1'b0},
    {32'hFFF0_0000, 4'b1000, 1'b0},
    {32'hFFFF_FFFF, 4'b1000, 1'b0},
    {32'h0030_0000, 4'b0000, 1'b1},
    {32'h2000_0000, 4'b0000, 1'b1},
    {32'hFFEF_FFFF, 4'b0000, 1'b1},
    {32'h0100_0000, 4'b0000, 1'b1}
  };

  task automatic check(input string req, input logic [3:0] es, input logic ee);
    checks++;
    if (slv_sel !== es || dec_err !== ee) begin
      fails++;
      $display("FAIL %s: sel=%b err=%b expected sel=%b err=%b", req, slv_sel, dec_err, es, ee);
    end
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n = 1'b0; boot_ext = pin; addr_start = 1'b0; remap_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic decode(input logic [31:0] a, input logic with_remap);
    @(negedge clk);
    addr = a; addr_start = 1'b1; remap_req = with_remap;
    @(negedge clk);
    addr_start = 1'b0; remap_req = 1'b0;
  endtask

  task automatic pulse_remap();
    @(negedge clk);
    remap_req = 1'b1;
    @(negedge clk);
    remap_req = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boot_ext = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 in reset", 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 4'b0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      decode(VEC[i][36:5], 1'b0);
      check($sformatf("R2/R4/R5 vector %0d", i), VEC[i][4:1], VEC[i][0]);
    end

    decode(32'h0000_1000, 1'b0);
    @(negedge clk); addr = 32'h3000_0000;
    @(negedge clk); addr = 32'hFFF0_0000;
    check("R6 hold without start", 4'b0001, 1'b0);

    @(negedge clk); boot_ext = 1'b1;
    decode(32'h0000_0000, 1'b0);
    check("R2 pin ignored after reset", 4'b0001, 1'b0);

    decode(32'h0000_0000, 1'b1);
    check("R3 same-cycle strobe uses old map", 4'b0001, 1'b0);
    decode(32'h0000_0000, 1'b0);
    check("R3 low region remapped to SRAM", 4'b0010, 1'b0);
    decode(32'h0010_0000, 1'b0);
    check("R4 ROM region fixed after remap", 4'b0001, 1'b0);
    decode(32'h1000_0000, 1'b0);
    check("R4 external region fixed after remap", 4'b0100, 1'b0);
    pulse_remap();
    decode(32'h0000_0100, 1'b0);
    check("R3 repeated strobe stays remapped", 4'b0010, 1'b0);

    do_reset(1'b0);
    @(negedge clk);
    check("R1 outputs cleared by second reset", 4'b0000, 1'b0);
    decode(32'h0000_0000, 1'b0);
    check("R1 reset clears remap", 4'b0001, 1'b0);
    pulse_remap();
    check("R6 mid-transfer remap has no effect", 4'b0001, 1'b0);
    decode(32'h0000_0000, 1'b0);
    check("R3 next phase sees remap", 4'b0010, 1'b0);

    do_reset(1'b1);
    decode(32'h000A_0000, 1'b0);
    check("R2 pin high boots external", 4'b0100, 1'b0);
    decode(32'h0010_0000, 1'b0);
    check("R4 ROM region with external boot", 4'b0001, 1'b0);
    decode(32'h5000_0000, 1'b0);
    check("R5 unmapped with external boot", 4'b0000, 1'b1);
    decode(32'h0000_0000, 1'b1);
    check("R3 old map on strobe cycle, external boot", 4'b0100, 1'b0);
    decode(32'h0000_0000, 1'b0);
    check("R3 remap overrides external boot", 4'b0010, 1'b0);
    check("R7 at most one select bit", (slv_sel & (slv_sel - 4'd1)) == 4'd0 ? slv_sel : 4'b0000, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule